// File: doc/BRIEF.md
# Dual 40-bit Saturating Accumulator

This block is the accumulation stage of a DSP datapath. It holds two 40-bit accumulators, A and B. Each has a 32-bit main field and eight guard bits on top, and both share one adder/subtractor. On every valid operation one accumulator is picked. It is both the source and the destination of that operation. The operation either adds a signed operand to the picked accumulator or loads the operand into it. The operand is one of two things: a 32-bit signed product, or a 16-bit data word that has been scaled. Either operand can be negated before it enters the adder. This makes multiply-subtract and multiply-negate possible without changing the stored values.

The unlimited result goes through optional limiting logic. The limit is either at the 32-bit range or at the full 40-bit range. Each accumulator has two flags:
- a guard-overflow flag, recomputed whenever that accumulator is written;
- a sticky saturation flag.

The saturation flag means one of two things, depending on the limiting mode. With limiting on, it means the result was clamped. With limiting off, it means the sign was lost. Combined flags OR the two accumulators' flags together. Three trap-request outputs tell the surrounding core that an arithmetic exception has occurred. The block is used by driving one operation per clock. Results and flags appear on the outputs one cycle later.

Top module: `dacc_unit`

## Requirements
- R1: After reset, both accumulators are zero, all six flags are low and all three trap requests are low.
- R2: When `op_valid_i` is 1 and `op_load_i` is 0, the accumulator chosen by `acc_sel_i` (0 = A, 1 = B) takes its old value plus the operand on the next clock. The other accumulator is unchanged. When `op_valid_i` is 0, neither accumulator changes.
- R3: When `op_valid_i` is 1 and `op_load_i` is 1, the chosen accumulator takes the operand itself, after limiting.
- R4: The operand source is picked by `src_data_i`. With `src_data_i` = 0, the operand is `prod_i` sign-extended from 32 bits. With `src_data_i` = 1, the operand is `data_i` sign-extended and placed at bits 31..16. It is then shifted by `shift_i`, read as a 4-bit two's-complement count: positive values shift arithmetically right, negative values shift left.
- R5: With `negate_i` = 1, the operand is replaced by its two's-complement negative before the add or load.
- R6: On each write to an accumulator, its guard-overflow flag (`oa_o` / `ob_o`) becomes 1 exactly when the unlimited result lies outside the signed 32-bit range, and 0 otherwise. It holds when the accumulator is not written. `oab_o` is `oa_o` OR `ob_o`.
- R7: With `sat_en_i` = 1 and `sat40_i` = 0, a result outside the signed 32-bit range is clamped to 0x00_7FFF_FFFF if the unlimited result is positive, or to 0xFF_8000_0000 if it is negative. The accumulator's saturation flag is then set.
- R8: With `sat_en_i` = 1 and `sat40_i` = 1, a result outside the signed 40-bit range is clamped to 0x7F_FFFF_FFFF or 0x80_0000_0000, following the sign of the unlimited result. The saturation flag is set.
- R9: With `sat_en_i` = 0, the accumulator takes the low 40 bits of the unlimited result. Its saturation flag is set when that result lies outside the signed 40-bit range, meaning the sign was lost.
- R10: `sa_o` and `sb_o` stay set until `clr_sab_i` is 1 for one cycle, which clears both. A new saturation event in that same cycle wins over the clear. `sab_o` is `sa_o` OR `sb_o`.
- R11: `trap_oa_o` = `oa_o` AND `ovf_a_te_i`, and `trap_ob_o` = `ob_o` AND `ovf_b_te_i`. `trap_sat_o` is 1 only when `sab_o` is 1, `sat_en_i` is 0 and `cat_te_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Perform an operation this cycle |
| op_load_i | input | 1 | 1 = load, 0 = accumulate |
| acc_sel_i | input | 1 | 0 = accumulator A, 1 = accumulator B |
| src_data_i | input | 1 | 0 = product operand, 1 = scaled data operand |
| prod_i | input | 32 | Signed product |
| data_i | input | 16 | Signed data word |
| shift_i | input | 4 | Signed scale count for the data word |
| negate_i | input | 1 | Negate the operand |
| sat_en_i | input | 1 | Enable limiting |
| sat40_i | input | 1 | 1 = limit at 40 bits, 0 = limit at 32 bits |
| clr_sab_i | input | 1 | Clear both saturation flags |
| ovf_a_te_i | input | 1 | Trap enable for guard overflow of A |
| ovf_b_te_i | input | 1 | Trap enable for guard overflow of B |
| cat_te_i | input | 1 | Trap enable for sign loss while limiting is off |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| oa_o | output | 1 | Guard overflow, A |
| ob_o | output | 1 | Guard overflow, B |
| sa_o | output | 1 | Saturation / sign loss, A |
| sb_o | output | 1 | Saturation / sign loss, B |
| oab_o | output | 1 | OR of the guard-overflow flags |
| sab_o | output | 1 | OR of the saturation flags |
| trap_oa_o | output | 1 | Trap request from A guard overflow |
| trap_ob_o | output | 1 | Trap request from B guard overflow |
| trap_sat_o | output | 1 | Trap request from sign loss |

## Verification
Some properties are checked by assertions on every cycle:
- idle cycles and the unselected accumulator keep their values;
- the saturation flags are sticky, and a clear removes them unless a new event arrives in the same cycle;
- an overflow flag holds between writes to its accumulator;
- a 32-bit-limited write always lands inside the 32-bit range;
- no sign-loss trap is raised while limiting is on.

The exact arithmetic needs the bench's reference model, run over random and directed operations. That covers operand scaling and negation, the clamp values and their direction, wrap-around with limiting off, and the flag values after each write.

// File: rtl/dacc_pkg.sv
`timescale 1ns/1ps
package dacc_pkg;

    // Limiting mode applied to the unlimited adder result.
    typedef enum logic [1:0] {
        LIM_NONE = 2'd0,
        LIM_32   = 2'd1,
        LIM_40   = 2'd2
    } lim_mode_e;

    // Per-write event flags produced by the adder stage.
    typedef struct packed {
        logic guard_ovf;
        logic sat_hit;
    } wr_evt_t;

endpackage

// File: rtl/dacc_operand.sv
`timescale 1ns/1ps
module dacc_operand #(
    parameter int PROD_W   = 32,
    parameter int DATA_W   = 16,
    parameter int FRAC_POS = 16,
    parameter int SH_W     = 4,
    parameter int EXT_W    = 42
) (
    input  logic [PROD_W-1:0]       prod_i,
    input  logic [DATA_W-1:0]       data_i,
    input  logic [SH_W-1:0]         shift_i,
    input  logic                    src_data_i,
    input  logic                    negate_i,
    output logic signed [EXT_W-1:0] opnd_o
);

    logic signed [EXT_W-1:0] prod_x;
    logic signed [EXT_W-1:0] data_x;
    logic signed [EXT_W-1:0] scaled;
    logic signed [EXT_W-1:0] base;
    logic [SH_W:0]           sh_ext;
    logic [SH_W:0]           sh_mag;

    // Product operand: sign extend to the internal width.
    always_comb prod_x = {{(EXT_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};

    // Data operand: sign extend, align to the fraction position.
    always_comb data_x = {{(EXT_W-DATA_W){data_i[DATA_W-1]}}, data_i} <<< FRAC_POS;

    // Shift count magnitude, one extra bit so the most negative count fits.
    always_comb begin
        sh_ext = {shift_i[SH_W-1], shift_i};
        sh_mag = shift_i[SH_W-1] ? (~sh_ext + 1'b1) : sh_ext;
    end

    always_comb begin
        if (shift_i[SH_W-1]) scaled = data_x <<< sh_mag;
        else                 scaled = data_x >>> sh_mag;
    end

    always_comb begin
        base   = src_data_i ? scaled : prod_x;
        opnd_o = negate_i ? -base : base;
    end

endmodule

// File: rtl/dacc_addsat.sv
`timescale 1ns/1ps
module dacc_addsat
    import dacc_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int MAIN_W = 32,
    parameter int EXT_W  = 42
) (
    input  logic [ACC_W-1:0]        acc_i,
    input  logic signed [EXT_W-1:0] opnd_i,
    input  logic                    load_i,
    input  logic                    sat_en_i,
    input  logic                    sat40_i,
    output logic [ACC_W-1:0]        res_o,
    output wr_evt_t                 evt_o
);

    localparam logic [ACC_W-1:0] POS_MAIN = {{(ACC_W-MAIN_W+1){1'b0}}, {(MAIN_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_MAIN = {{(ACC_W-MAIN_W+1){1'b1}}, {(MAIN_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] POS_FULL = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_FULL = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [EXT_W-1:0] acc_x;
    logic signed [EXT_W-1:0] src_x;
    logic signed [EXT_W-1:0] sum;
    logic                    fit_main;
    logic                    fit_full;
    logic                    neg_res;
    lim_mode_e               mode;

    always_comb begin
        acc_x = {{(EXT_W-ACC_W){acc_i[ACC_W-1]}}, acc_i};
        src_x = load_i ? '0 : acc_x;
        sum   = src_x + opnd_i;
    end

    // Range tests on the unlimited result.
    always_comb begin
        fit_main = (&sum[EXT_W-1:MAIN_W-1]) | ~(|sum[EXT_W-1:MAIN_W-1]);
        fit_full = (&sum[EXT_W-1:ACC_W-1])  | ~(|sum[EXT_W-1:ACC_W-1]);
        neg_res  = sum[EXT_W-1];
    end

    always_comb begin
        if (!sat_en_i)    mode = LIM_NONE;
        else if (sat40_i) mode = LIM_40;
        else              mode = LIM_32;
    end

    always_comb begin
        res_o           = sum[ACC_W-1:0];
        evt_o.guard_ovf = ~fit_main;
        evt_o.sat_hit   = 1'b0;
        unique case (mode)
            LIM_NONE: begin
                evt_o.sat_hit = ~fit_full;
            end
            LIM_32: begin
                evt_o.sat_hit = ~fit_main;
                if (!fit_main) res_o = neg_res ? NEG_MAIN : POS_MAIN;
            end
            LIM_40: begin
                evt_o.sat_hit = ~fit_full;
                if (!fit_full) res_o = neg_res ? NEG_FULL : POS_FULL;
            end
            default: begin
                res_o = sum[ACC_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/dacc_status.sv
`timescale 1ns/1ps
module dacc_status
    import dacc_pkg::*;
#(
    parameter int N_ACC = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  wr_evt_t          evt_i,
    input  logic             clr_sat_i,
    input  logic             sat_en_i,
    input  logic [N_ACC-1:0] ovf_te_i,
    input  logic             cat_te_i,
    output logic [N_ACC-1:0] ovf_q_o,
    output logic [N_ACC-1:0] sat_q_o,
    output logic [N_ACC-1:0] trap_ovf_o,
    output logic             trap_sat_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q_o <= '0;
            sat_q_o <= '0;
        end else begin
            for (int i = 0; i < N_ACC; i++) begin
                if (wr_en_i && sel_i == SEL_W'(i)) begin
                    ovf_q_o[i] <= evt_i.guard_ovf;
                end
                if (wr_en_i && sel_i == SEL_W'(i) && evt_i.sat_hit) begin
                    sat_q_o[i] <= 1'b1;
                end else if (clr_sat_i) begin
                    sat_q_o[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        trap_ovf_o = ovf_q_o & ovf_te_i;
        trap_sat_o = (|sat_q_o) & ~sat_en_i & cat_te_i;
    end

    AST_SIGN_TRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        sat_en_i |-> !trap_sat_o) else $error("sign-loss trap while limiting on"); // R11

    for (genvar g = 0; g < N_ACC; g++) begin : g_chk
        AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (sat_q_o[g] && !clr_sat_i) |=> sat_q_o[g]) else $error("saturation flag dropped"); // R10
        AST_SAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_sat_i && !(wr_en_i && sel_i == SEL_W'(g) && evt_i.sat_hit)) |=> !sat_q_o[g])
            else $error("saturation flag not cleared"); // R10
        AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && sel_i == SEL_W'(g)) |=> $stable(ovf_q_o[g]))
            else $error("overflow flag moved without write"); // R6
    end

endmodule

// File: rtl/dacc_unit.sv
`timescale 1ns/1ps
module dacc_unit
    import dacc_pkg::*;
#(
    parameter int ACC_W    = 40,
    parameter int MAIN_W   = 32,
    parameter int PROD_W   = 32,
    parameter int DATA_W   = 16,
    parameter int FRAC_POS = 16,
    parameter int SH_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic              op_load_i,
    input  logic              acc_sel_i,
    input  logic              src_data_i,
    input  logic [PROD_W-1:0] prod_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SH_W-1:0]   shift_i,
    input  logic              negate_i,
    input  logic              sat_en_i,
    input  logic              sat40_i,
    input  logic              clr_sab_i,
    input  logic              ovf_a_te_i,
    input  logic              ovf_b_te_i,
    input  logic              cat_te_i,
    output logic [ACC_W-1:0]  acc_a_o,
    output logic [ACC_W-1:0]  acc_b_o,
    output logic              oa_o,
    output logic              ob_o,
    output logic              sa_o,
    output logic              sb_o,
    output logic              oab_o,
    output logic              sab_o,
    output logic              trap_oa_o,
    output logic              trap_ob_o,
    output logic              trap_sat_o
);

    localparam int EXT_W = ACC_W + 2;
    localparam int N_ACC = 2;
    localparam int SEL_W = 1;

    logic [ACC_W-1:0]        acc_q [N_ACC];
    logic [ACC_W-1:0]        acc_src;
    logic [ACC_W-1:0]        acc_res;
    logic signed [EXT_W-1:0] opnd;
    wr_evt_t                 evt;
    logic [N_ACC-1:0]        ovf_q;
    logic [N_ACC-1:0]        sat_q;
    logic [N_ACC-1:0]        trap_ovf;

    always_comb acc_src = acc_q[acc_sel_i];

    dacc_operand #(
        .PROD_W(PROD_W), .DATA_W(DATA_W), .FRAC_POS(FRAC_POS),
        .SH_W(SH_W), .EXT_W(EXT_W)
    ) u_operand (
        .prod_i(prod_i), .data_i(data_i), .shift_i(shift_i),
        .src_data_i(src_data_i), .negate_i(negate_i), .opnd_o(opnd)
    );

    dacc_addsat #(
        .ACC_W(ACC_W), .MAIN_W(MAIN_W), .EXT_W(EXT_W)
    ) u_addsat (
        .acc_i(acc_src), .opnd_i(opnd), .load_i(op_load_i),
        .sat_en_i(sat_en_i), .sat40_i(sat40_i),
        .res_o(acc_res), .evt_o(evt)
    );

    dacc_status #(
        .N_ACC(N_ACC), .SEL_W(SEL_W)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .wr_en_i(op_valid_i), .sel_i(acc_sel_i),
        .evt_i(evt), .clr_sat_i(clr_sab_i), .sat_en_i(sat_en_i),
        .ovf_te_i({ovf_b_te_i, ovf_a_te_i}), .cat_te_i(cat_te_i),
        .ovf_q_o(ovf_q), .sat_q_o(sat_q), .trap_ovf_o(trap_ovf),
        .trap_sat_o(trap_sat_o)
    );

    // Accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ACC; i++) acc_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_ACC; i++) begin
                if (op_valid_i && acc_sel_i == SEL_W'(i)) acc_q[i] <= acc_res;
            end
        end
    end

    always_comb begin
        acc_a_o   = acc_q[0];
        acc_b_o   = acc_q[1];
        oa_o      = ovf_q[0];
        ob_o      = ovf_q[1];
        sa_o      = sat_q[0];
        sb_o      = sat_q[1];
        oab_o     = |ovf_q;
        sab_o     = |sat_q;
        trap_oa_o = trap_ovf[0];
        trap_ob_o = trap_ovf[1];
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> ($stable(acc_a_o) && $stable(acc_b_o)))
        else $error("accumulator moved while idle"); // R2
    AST_UNSEL_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && acc_sel_i) |=> $stable(acc_a_o))
        else $error("A moved while B selected"); // R2
    AST_UNSEL_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !acc_sel_i) |=> $stable(acc_b_o))
        else $error("B moved while A selected"); // R2
    AST_MAIN_LIMIT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !acc_sel_i && sat_en_i && !sat40_i) |=>
        ((&acc_a_o[ACC_W-1:MAIN_W-1]) || !(|acc_a_o[ACC_W-1:MAIN_W-1])))
        else $error("32-bit limited result out of range"); // R7

endmodule

// File: tb/dacc_unit_bench.sv
`timescale 1ns/1ps
module dacc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 0, op_load_i = 0, acc_sel_i = 0, src_data_i = 0;
    logic [31:0] prod_i = '0;
    logic [15:0] data_i = '0;
    logic [3:0]  shift_i = '0;
    logic        negate_i = 0, sat_en_i = 0, sat40_i = 0, clr_sab_i = 0;
    logic        ovf_a_te_i = 0, ovf_b_te_i = 0, cat_te_i = 0;
    logic [39:0] acc_a_o, acc_b_o;
    logic        oa_o, ob_o, sa_o, sb_o, oab_o, sab_o;
    logic        trap_oa_o, trap_ob_o, trap_sat_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [39:0] m_acc [2];
    logic        m_ov  [2];
    logic        m_sa  [2];

    always #2.5 clk = ~clk;

    dacc_unit u_dacc_unit (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_load_i(op_load_i),
        .acc_sel_i(acc_sel_i), .src_data_i(src_data_i), .prod_i(prod_i),
        .data_i(data_i), .shift_i(shift_i), .negate_i(negate_i),
        .sat_en_i(sat_en_i), .sat40_i(sat40_i), .clr_sab_i(clr_sab_i),
        .ovf_a_te_i(ovf_a_te_i), .ovf_b_te_i(ovf_b_te_i), .cat_te_i(cat_te_i),
        .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .oa_o(oa_o), .ob_o(ob_o),
        .sa_o(sa_o), .sb_o(sb_o), .oab_o(oab_o), .sab_o(sab_o),
        .trap_oa_o(trap_oa_o), .trap_ob_o(trap_ob_o), .trap_sat_o(trap_sat_o)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    function automatic logic fits(input logic signed [41:0] v, input int w);
        longint lim = longint'(1) << (w - 1);
        longint sv = longint'(v);
        return (sv >= -lim) && (sv < lim);
    endfunction

    // Operand per R4 / R5.
    function automatic logic signed [41:0] ref_opnd();
        longint d;
        int     sh;
        if (!src_data_i) d = longint'($signed(prod_i));
        else begin
            d  = longint'($signed(data_i)) * 65536;
            sh = int'($signed(shift_i));
            if (sh < 0) d = d * (longint'(1) << (-sh));
            else        d = d >>> sh;
        end
        if (negate_i) d = -d;
        return d[41:0];
    endfunction

    task automatic model_step();
        logic signed [41:0] sum;
        logic [39:0]        nv;
        logic               hit, f32, f40;
        int                 s;
        s = int'(acc_sel_i);
        if (clr_sab_i) begin
            m_sa[0] = 1'b0;
            m_sa[1] = 1'b0;
        end
        if (op_valid_i) begin
            sum = (op_load_i ? 42'sd0 : {{2{m_acc[s][39]}}, m_acc[s]}) + ref_opnd();
            f32 = fits(sum, 32);
            f40 = fits(sum, 40);
            nv  = sum[39:0];
            hit = 1'b0;
            if (!sat_en_i) hit = !f40;
            else if (sat40_i) begin
                if (!f40) begin
                    hit = 1'b1;
                    nv  = sum[41] ? 40'h80_0000_0000 : 40'h7F_FFFF_FFFF;
                end
            end else if (!f32) begin
                hit = 1'b1;
                nv  = sum[41] ? 40'hFF_8000_0000 : 40'h00_7FFF_FFFF;
            end
            m_acc[s] = nv;
            m_ov[s]  = !f32;
            if (hit) m_sa[s] = 1'b1;
        end
    endtask

    task automatic compare_all(input string acc_req);
        chk(acc_req, acc_a_o, m_acc[0]);
        chk(acc_req, acc_b_o, m_acc[1]);
        chk("R6 oa", 40'(oa_o), 40'(m_ov[0]));
        chk("R6 ob", 40'(ob_o), 40'(m_ov[1]));
        chk("R6 oab", 40'(oab_o), 40'(m_ov[0] | m_ov[1]));
        chk("R10 sa", 40'(sa_o), 40'(m_sa[0]));
        chk("R10 sb", 40'(sb_o), 40'(m_sa[1]));
        chk("R10 sab", 40'(sab_o), 40'(m_sa[0] | m_sa[1]));
        chk("R11 trap_oa", 40'(trap_oa_o), 40'(m_ov[0] & ovf_a_te_i));
        chk("R11 trap_ob", 40'(trap_ob_o), 40'(m_ov[1] & ovf_b_te_i));
        chk("R11 trap_sat", 40'(trap_sat_o),
            40'((m_sa[0] | m_sa[1]) & !sat_en_i & cat_te_i));
    endtask

    // Called at a falling edge with inputs already driven.
    task automatic apply(input string acc_req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all(acc_req);
    endtask

    task automatic set_op(input logic v, input logic ld, input logic sel, input logic src,
                          input logic [31:0] p, input logic [15:0] d, input logic [3:0] sh,
                          input logic ng, input logic se, input logic s40, input logic clr);
        op_valid_i = v; op_load_i = ld; acc_sel_i = sel; src_data_i = src;
        prod_i = p; data_i = d; shift_i = sh; negate_i = ng;
        sat_en_i = se; sat40_i = s40; clr_sab_i = clr;
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 2; i++) begin
            m_acc[i] = '0; m_ov[i] = 1'b0; m_sa[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compare_all("R1");

        ovf_a_te_i = 1; ovf_b_te_i = 1; cat_te_i = 1;
        // R3: load A with largest positive 32-bit product
        set_op(1, 1, 0, 0, 32'h7FFF_FFFF, 0, 0, 0, 1, 0, 0); apply("R3 load");
        chk("R3 load value", acc_a_o, 40'h00_7FFF_FFFF);
        // R7: add one with 32-bit limiting clamps positive
        set_op(1, 0, 0, 0, 32'h1, 0, 0, 0, 1, 0, 0); apply("R7 clamp");
        chk("R7 clamp value", acc_a_o, 40'h00_7FFF_FFFF);
        chk("R7 sa set", 40'(sa_o), 40'd1);
        chk("R6 oa set", 40'(oa_o), 40'd1);
        // R10: idle clear drops SA, R6 oa holds
        set_op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1); apply("R2 idle");
        chk("R10 cleared", 40'(sab_o), 40'd0);
        chk("R6 hold", 40'(oa_o), 40'd1);
        // R5: load B with negated most negative product
        set_op(1, 1, 1, 0, 32'h8000_0000, 0, 0, 1, 0, 0, 0); apply("R5 negate");
        chk("R5 value", acc_b_o, 40'h00_8000_0000);
        // R4: data left shift by 8
        set_op(1, 1, 0, 1, 0, 16'h4000, 4'h8, 0, 0, 0, 0); apply("R4 data left");
        chk("R4 left value", acc_a_o, 40'h40_0000_0000);
        // R9: wrap with limiting off, sign lost, trap requested
        set_op(1, 0, 0, 1, 0, 16'h4000, 4'h8, 0, 0, 0, 0); apply("R9 wrap");
        chk("R9 wrap value", acc_a_o, 40'h80_0000_0000);
        chk("R11 sign trap", 40'(trap_sat_o), 40'd1);
        // R8: 40-bit limiting, negative direction
        set_op(1, 0, 0, 1, 0, 16'h4000, 4'h8, 1, 1, 1, 1); apply("R8 clamp");
        chk("R8 clamp value", acc_a_o, 40'h80_0000_0000);
        chk("R10 set beats clear", 40'(sa_o), 40'd1);
        set_op(1, 1, 1, 1, 0, 16'h7FFF, 4'h8, 0, 1, 1, 0); apply("R3 load");
        set_op(1, 0, 1, 1, 0, 16'h7FFF, 4'h8, 0, 1, 1, 0); apply("R8 clamp");
        chk("R8 pos clamp", acc_b_o, 40'h7F_FFFF_FFFF);
        // R4: arithmetic right shift by 4
        set_op(1, 1, 0, 1, 0, 16'h8000, 4'h4, 0, 1, 0, 0); apply("R4 data right");
        chk("R4 right value", acc_a_o, 40'hFF_F800_0000);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] p;
            string tag;
            p = $urandom();
            if ($urandom() % 4 == 0) p = p >>> ($urandom() % 24);
            set_op(($urandom() % 8) != 0, ($urandom() % 8) == 0, 1'($urandom()),
                   1'($urandom()), p, 16'($urandom()), 4'($urandom()), 1'($urandom()),
                   ($urandom() % 4) != 0, 1'($urandom()), ($urandom() % 16) == 0);
            ovf_a_te_i = 1'($urandom()); ovf_b_te_i = 1'($urandom()); cat_te_i = 1'($urandom());
            if (!op_valid_i)      tag = "R2 idle";
            else if (op_load_i)   tag = "R3 load";
            else if (!sat_en_i)   tag = "R9 wrap";
            else if (sat40_i)     tag = "R8 sat40";
            else                  tag = "R7 sat32";
            apply(tag);
        end
        finish_run();
    end

endmodule